// File: doc/BRIEF.md
# Per-Lane Receive Polarity Detector

This block sits on the receive side of a multi-lane serial link, after the 8b/10b decoder and symbol alignment. Each lane scans its decoded symbol stream for training ordered sets while link training is active. A training set starts with a comma symbol (K28.5, byte 0xBC with the K flag set) and is 16 symbols long. Positions 6 to 15 carry a repeated identifier byte. For a normal pair the identifier is 0x4A (first training set) or 0x45 (second training set). If the differential pair is swapped, the decoder instead produces the bitwise complements, 0xB5 or 0xBA.

When a lane completes a set whose ten identifier symbols are all the same complemented value, that lane latches an inversion flag. From the next symbol on, it complements every received data character. Each lane decides on its own, so lanes of one link may end up with different settings. No software action is involved. The transmit side is never touched. The flag is cleared when the link controller signals entry to the Detect state. The flag is frozen whenever training is not active.

Each lane runs a three-state scanner:
- `ST_HUNT` waits for a comma.
- `ST_HEAD` counts header positions 1 to 5.
- `ST_IDENT` checks positions 6 to 15.

The scanner moves between states as follows:
- A comma moves it from any state to `ST_HEAD`.
- After position 5 it goes from `ST_HEAD` to `ST_IDENT`.
- It returns from `ST_IDENT` to `ST_HUNT` when a set completes at position 15.
- It aborts to `ST_HUNT` on a mismatch, an unexpected K symbol, a disparity error, training going inactive, or a clear.

Top module: `rx_lane_polarity`

## Requirements
- R1: After reset, every lane's inversion flag is 0 and no output symbol is marked valid.
- R2: While training is active, a lane that receives a comma followed by 5 header data symbols and then ten identifier symbols all equal to 0xB5 sets its inversion flag in the cycle after the last identifier. Its next data symbol is complemented.
- R3: The same happens for ten identifier symbols all equal to 0xBA.
- R4: A complete set whose identifiers are all 0x4A or all 0x45 leaves the flag unchanged, and data passes unmodified.
- R5: A set whose identifier positions do not all hold the same value is ignored.
- R6: Each lane keeps its own flag. Lanes receiving inverted sets are flagged while their neighbours are not.
- R7: Output valid and K flag equal the inputs one cycle earlier. Output data equals the input byte one cycle earlier, complemented when that lane's flag was set and the symbol was not a K symbol. K symbols pass unchanged.
- R8: A one-cycle pulse on the Detect-entry clear resets every lane's flag in the next cycle and abandons any set being scanned.
- R9: While training is inactive, the flags do not change, and complete inverted sets have no effect.
- R10: A disparity error anywhere in a set aborts that set. A comma received part-way through a set restarts scanning at position 1.
- R11: Cycles with symbol valid low are skipped and do not advance the position count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_active | input | 1 | High while link training is in progress |
| detect_clear | input | 1 | Pulse on entry to Detect; clears all flags |
| rx_valid | input | LANES | Per-lane decoded symbol valid |
| rx_k | input | LANES | Per-lane K-character flag |
| rx_disp_err | input | LANES | Per-lane disparity error |
| rx_data | input | LANES*8 | Per-lane decoded byte, lane i in bits [8i+7:8i] |
| out_valid | output | LANES | Corrected symbol valid |
| out_k | output | LANES | Corrected symbol K flag |
| out_data | output | LANES*8 | Corrected byte per lane |
| lane_inverted | output | LANES | Per-lane inversion flag |

## Verification
A scanner that loses its position count, or that accepts a mixed or error-marked set, changes the value of `lane_inverted` one cycle after the final identifier symbol. From the next received data character it also complements (or fails to complement) `out_data`. A flag stuck or set on the wrong lane corrupts every following data byte on that lane with a one-cycle delay. Any such fault therefore appears at the ports within one symbol of the set's end. A fault in the data register shows on the very next valid symbol.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
    localparam int         SYM_W    = 8;
    localparam int         SET_LEN  = 16;
    localparam int         ID_FIRST = 6;
    localparam int         POS_W    = $clog2(SET_LEN);
    localparam logic [7:0] COMMA    = 8'hBC;
    localparam logic [7:0] ID_A     = 8'h4A;
    localparam logic [7:0] ID_B     = 8'h45;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HEAD,
        ST_IDENT
    } scan_state_e;

    function automatic logic is_ident(input logic [7:0] b);
        return (b == ID_A) || (b == ID_B) || (b == ~ID_A) || (b == ~ID_B);
    endfunction

    function automatic logic is_flipped(input logic [7:0] b);
        return (b == ~ID_A) || (b == ~ID_B);
    endfunction
endpackage

// File: rtl/rxpol_scan.sv
module rxpol_scan
    import rxpol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             train,
    input  logic             valid,
    input  logic             is_k,
    input  logic             derr,
    input  logic [SYM_W-1:0] data,
    output logic             found_inv
);
    scan_state_e      state, nstate;
    logic [POS_W-1:0] pos, npos;
    logic [SYM_W-1:0] ref_id, nref_id;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            pos    <= '0;
            ref_id <= '0;
        end else begin
            state  <= nstate;
            pos    <= npos;
            ref_id <= nref_id;
        end
    end

    // next state and outputs
    always_comb begin
        nstate    = state;
        npos      = pos;
        nref_id   = ref_id;
        found_inv = 1'b0;
        if (clear) begin
            nstate = ST_HUNT;
            npos   = '0;
        end else if (valid) begin
            if (!train || derr) begin
                nstate = ST_HUNT;
            end else if (is_k && data == COMMA) begin
                nstate = ST_HEAD;
                npos   = POS_W'(1);
            end else begin
                unique case (state)
                    ST_HUNT: nstate = ST_HUNT;
                    ST_HEAD: begin
                        if (is_k) begin
                            nstate = ST_HUNT;
                        end else begin
                            npos = pos + 1'b1;
                            if (pos == POS_W'(ID_FIRST - 1)) nstate = ST_IDENT;
                        end
                    end
                    ST_IDENT: begin
                        if (is_k) begin
                            nstate = ST_HUNT;
                        end else if (pos == POS_W'(ID_FIRST)) begin
                            if (is_ident(data)) begin
                                nref_id = data;
                                npos    = pos + 1'b1;
                            end else begin
                                nstate = ST_HUNT;
                            end
                        end else if (data != ref_id) begin
                            nstate = ST_HUNT;
                        end else if (pos == POS_W'(SET_LEN - 1)) begin
                            nstate    = ST_HUNT;
                            found_inv = is_flipped(ref_id);
                        end else begin
                            npos = pos + 1'b1;
                        end
                    end
                    default: nstate = ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/rxpol_fix.sv
module rxpol_fix
    import rxpol_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             set_inv,
    input  logic             in_valid,
    input  logic             in_k,
    input  logic [SYM_W-1:0] in_data,
    output logic             o_valid,
    output logic             o_k,
    output logic [SYM_W-1:0] o_data,
    output logic             inv_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       inv_flag <= 1'b0;
        else if (clear)   inv_flag <= 1'b0;
        else if (set_inv) inv_flag <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_k     <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= in_valid;
            o_k     <= in_k;
            o_data  <= in_data ^ {SYM_W{inv_flag & ~in_k}};
        end
    end
endmodule

// File: rtl/rx_lane_polarity.sv
module rx_lane_polarity
    import rxpol_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   train_active,
    input  logic                   detect_clear,
    input  logic [LANES-1:0]       rx_valid,
    input  logic [LANES-1:0]       rx_k,
    input  logic [LANES-1:0]       rx_disp_err,
    input  logic [LANES*SYM_W-1:0] rx_data,
    output logic [LANES-1:0]       out_valid,
    output logic [LANES-1:0]       out_k,
    output logic [LANES*SYM_W-1:0] out_data,
    output logic [LANES-1:0]       lane_inverted
);
    logic [LANES-1:0] hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rxpol_scan u_scan (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (detect_clear),
            .train     (train_active),
            .valid     (rx_valid[g]),
            .is_k      (rx_k[g]),
            .derr      (rx_disp_err[g]),
            .data      (rx_data[g*SYM_W +: SYM_W]),
            .found_inv (hit[g])
        );
        rxpol_fix u_fix (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (detect_clear),
            .set_inv  (hit[g]),
            .in_valid (rx_valid[g]),
            .in_k     (rx_k[g]),
            .in_data  (rx_data[g*SYM_W +: SYM_W]),
            .o_valid  (out_valid[g]),
            .o_k      (out_k[g]),
            .o_data   (out_data[g*SYM_W +: SYM_W]),
            .inv_flag (lane_inverted[g])
        );
    end
endmodule

// File: rtl/rxpol_chk.sv
module rxpol_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 train_active,
    input logic                 detect_clear,
    input logic [LANES-1:0]     rx_valid,
    input logic [LANES-1:0]     rx_k,
    input logic [LANES*8-1:0]   rx_data,
    input logic [LANES-1:0]     out_valid,
    input logic [LANES-1:0]     out_k,
    input logic [LANES*8-1:0]   out_data,
    input logic [LANES-1:0]     lane_inverted
);
    // R9
    frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!train_active && !detect_clear) |=> $stable(lane_inverted));

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        detect_clear |=> (lane_inverted == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R2
        rise_in_training_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lane_inverted[g]) |-> $past(train_active && rx_valid[g] && !rx_k[g]));

        // R7
        valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[g] |=> out_valid[g]);

        // R7
        idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_valid[g] |=> !out_valid[g]);

        // R7
        data_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[g] && !rx_k[g]) |=>
            (out_data[g*8 +: 8] == $past(rx_data[g*8 +: 8] ^ {8{lane_inverted[g]}})));

        // R7
        k_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[g] && rx_k[g]) |=>
            (out_k[g] && out_data[g*8 +: 8] == $past(rx_data[g*8 +: 8])));
    end
endmodule

bind rx_lane_polarity rxpol_chk #(.LANES(LANES)) u_rxpol_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .train_active  (train_active),
    .detect_clear  (detect_clear),
    .rx_valid      (rx_valid),
    .rx_k          (rx_k),
    .rx_data       (rx_data),
    .out_valid     (out_valid),
    .out_k         (out_k),
    .out_data      (out_data),
    .lane_inverted (lane_inverted)
);

// File: tb/test_rx_lane_polarity.sv
module test_rx_lane_polarity;
    localparam int CLK_PERIOD = 10;
    localparam int L = 4;
    localparam logic [7:0] NA = 8'h4A, NB = 8'h45, IA = 8'hB5, IB = 8'hBA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_active = 1'b0, detect_clear = 1'b0;
    logic [L-1:0] rx_valid = '0, rx_k = '0, rx_disp_err = '0;
    logic [L*8-1:0] rx_data = '0;
    logic [L-1:0] out_valid, out_k, lane_inverted;
    logic [L*8-1:0] out_data;

    logic [L-1:0] exp_inv = '0;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_lane_polarity #(.LANES(L)) i_rx_lane_polarity (
        .clk(clk), .rst_n(rst_n), .train_active(train_active), .detect_clear(detect_clear),
        .rx_valid(rx_valid), .rx_k(rx_k), .rx_disp_err(rx_disp_err), .rx_data(rx_data),
        .out_valid(out_valid), .out_k(out_k), .out_data(out_data), .lane_inverted(lane_inverted)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic inv, input logic k);
        return (inv && !k) ? ~b : b;
    endfunction

    function automatic logic flipped_id(input logic [7:0] b);
        return (b == IA) || (b == IB);
    endfunction

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // apply current rx_* at a negedge, sample outputs just after the next posedge
    task automatic cycle(input string tag, input logic [L-1:0] v, input logic [L-1:0] k,
                         input logic [L-1:0] e, input logic [L*8-1:0] d, input logic clr);
        @(negedge clk);
        rx_valid = v; rx_k = k; rx_disp_err = e; rx_data = d; detect_clear = clr;
        @(posedge clk);
        #1;
        for (int i = 0; i < L; i++) begin
            check({tag, " valid"}, out_valid[i] == v[i], 32'(out_valid[i]), 32'(v[i]));
            if (v[i]) begin
                check({tag, " k"}, out_k[i] == k[i], 32'(out_k[i]), 32'(k[i]));
                check({tag, " data"}, out_data[i*8 +: 8] == exp_byte(d[i*8 +: 8], exp_inv[i], k[i]),
                      32'(out_data[i*8 +: 8]), 32'(exp_byte(d[i*8 +: 8], exp_inv[i], k[i])));
            end
        end
    endtask

    task automatic check_flags(input string tag);
        check(tag, lane_inverted == exp_inv, 32'(lane_inverted), 32'(exp_inv));
    endtask

    // one training set; alt_pos substitutes alt_ids at that position, err_pos marks a disparity error
    task automatic send_set(input string tag, input logic [L*8-1:0] ids, input int alt_pos,
                            input logic [L*8-1:0] alt_ids, input int err_pos, input int last_pos,
                            input logic gaps);
        for (int p = 0; p <= last_pos; p++) begin
            logic [L*8-1:0] d;
            if (gaps && ($urandom % 3 == 0))
                cycle({tag, " gap"}, '0, '0, '0, L*8'($urandom), 1'b0); // R11
            if (p == 0) d = {L{8'hBC}};
            else if (p < 6) d = {L{8'(p * 17)}};
            else d = (p == alt_pos) ? alt_ids : ids;
            cycle(tag, '1, (p == 0) ? '1 : '0, (p == err_pos) ? '1 : '0, d, 1'b0);
        end
    endtask

    task automatic pulse_clear(input string tag);
        cycle(tag, '0, '0, '0, '0, 1'b1);
        exp_inv = '0;
        cycle(tag, '0, '0, '0, '0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        check("R1 flags", lane_inverted == '0, 32'(lane_inverted), 0);
        check("R1 valid", out_valid == '0, 32'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        train_active = 1'b1;

        // R4 normal identifiers
        send_set("R4", {NB, NA, NB, NA}, -1, '0, -1, 15, 1'b0);
        check_flags("R4 flags");

        // R5 mixed identifiers on every lane
        send_set("R5", {IA, IB, IA, IB}, 9, {NA, NA, NA, NA}, -1, 15, 1'b0);
        check_flags("R5 flags");

        // R2 R3 R6 R11 per-lane decisions with idle gaps
        send_set("R6", {NB, IB, NA, IA}, -1, '0, -1, 15, 1'b1);
        exp_inv = 4'b0101;
        check_flags("R6 flags");
        cycle("R2 next data", '1, '0, '0, {8'h12, 8'h34, 8'h56, 8'h78}, 1'b0);

        // R7 random stream, training off so flags hold
        train_active = 1'b0;
        for (int n = 0; n < 300; n++)
            cycle("R7", L'($urandom), L'($urandom), '0, L*8'($urandom), 1'b0);

        // R9 inverted sets ignored while training inactive
        send_set("R9", {IA, IA, IB, IB}, -1, '0, -1, 15, 1'b0);
        check_flags("R9 flags");

        // R8 clear
        train_active = 1'b1;
        pulse_clear("R8");
        check_flags("R8 flags");

        // R10 disparity error aborts
        send_set("R10 derr", {IA, IA, IB, IB}, -1, '0, 8, 15, 1'b0);
        check_flags("R10 derr flags");

        // R10 comma restart: partial normal set then full set
        send_set("R10 part", {NA, NA, NA, NA}, -1, '0, -1, 9, 1'b0);
        send_set("R10 full", {IA, NB, NB, NB}, -1, '0, -1, 15, 1'b0);
        exp_inv = 4'b1000;
        check_flags("R10 restart flags");

        // R8 clear abandons a set in progress
        send_set("R8 part", {IB, IB, IB, IB}, -1, '0, -1, 10, 1'b0);
        pulse_clear("R8 mid");
        for (int p = 11; p < 16; p++)
            cycle("R8 tail", '1, '0, '0, {L{IB}}, 1'b0);
        check_flags("R8 mid flags");

        // R2 R3 R6 random per-lane sets
        for (int n = 0; n < 20; n++) begin
            logic [L*8-1:0] ids;
            logic [L-1:0] want;
            for (int i = 0; i < L; i++) begin
                case ($urandom % 4)
                    0: ids[i*8 +: 8] = NA;
                    1: ids[i*8 +: 8] = NB;
                    2: ids[i*8 +: 8] = IA;
                    default: ids[i*8 +: 8] = IB;
                endcase
                want[i] = flipped_id(ids[i*8 +: 8]);
            end
            pulse_clear("R8 rnd");
            send_set("R3 rnd", ids, -1, '0, -1, 15, 1'(($urandom % 2)));
            exp_inv = want;
            check_flags("R6 rnd flags");
            cycle("R7 rnd", '1, '0, '0, L*8'($urandom), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule